// File: doc/BRIEF.md
# Compressed First-Level TLB

This block is a small, fully associative first-level translation cache in which one entry stands for a naturally aligned run of eight 4KB pages. Each entry keeps the virtual page number with its three low bits dropped as its tag. It also keeps one physical page number whose upper part is shared by the whole run, an attribute field, and an 8-bit vector that marks which of the eight pages in the run are valid. A 2MB or 1GB page is held as a single translation, and its vector is not consulted.

A lookup is combinational. The block compares the request against every entry and returns a hit, the reconstructed physical page number, the attributes and the page size. On a miss it raises a walk request that carries the virtual page number toward the second-level TLB. Refills arrive in the compressed form: the requesting VPN, a size level, a physical page number, the valid vector, the index of the requested page within the run, and attributes. Shootdowns either clear the whole array or remove only the entries that cover one virtual page.

Top module: `ctlb_l1`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and raises a walk request.
- R2: A 4KB lookup hits only when VPN[26:3] equals an entry's tag and bit VPN[2:0] of that entry's valid vector is 1. A page of the run whose bit is 0 misses.
- R3: On a 4KB hit, lk_ppn is the stored PPN[23:3] followed by VPN[2:0]. lk_attr is the stored attributes and lk_level is 0.
- R4: Level 1 (2MB) matches on VPN[26:9] and returns {PPN[23:9], VPN[8:0]}. Level 2 (1GB) matches on VPN[26:18] and returns {PPN[23:18], VPN[17:0]}. For both, the valid vector is ignored.
- R5: In the same cycle as a lookup that misses, walk_valid is 1 and walk_vpn equals lk_vpn. A lookup that hits raises no walk.
- R6: A refill whose level and tag match a valid entry overwrites that entry and does not allocate a second one.
- R7: Any other accepted refill goes into the slot named by a round-robin pointer over 8 slots, and the pointer then advances. The ninth distinct refill therefore evicts the first.
- R8: A refill is discarded if its level is 3, or if it is a level 0 refill whose valid-vector bit at rf_pteidx is 0.
- R9: An sfence with sf_has_addr=0 invalidates every entry. With sf_has_addr=1 it removes only the entries whose tag covers sf_vpn. A refill in the same cycle as any sfence is discarded.
- R10: A refill becomes visible to lookups from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 24 | Reconstructed physical page number |
| lk_attr | output | 8 | Attributes of hit entry |
| lk_level | output | 2 | Page size of hit entry (0 4KB, 1 2MB, 2 1GB) |
| walk_valid | output | 1 | Walk request on miss |
| walk_vpn | output | 27 | VPN of the walk request |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | 27 | VPN that caused the refill |
| rf_level | input | 2 | Refill page size |
| rf_ppn | input | 24 | Refill physical page number |
| rf_vmask | input | 8 | Per-page valid vector of the run |
| rf_pteidx | input | 3 | Index of the requested page in the run |
| rf_attr | input | 8 | Refill attributes |
| sf_valid | input | 1 | Shootdown strobe |
| sf_has_addr | input | 1 | Shootdown is limited to one address |
| sf_vpn | input | 27 | Shootdown virtual page number |

## Verification
Any corrupt tag, valid vector or level appears at the very next lookup of an affected page as a wrong hit, a wrong physical page number or a spurious walk request, because lookup is combinational. A pointer that moves wrongly, or a missing merge on refill, stays hidden until the pointer wraps. It then evicts the wrong entry, so the scenarios fill the array past eight slots and probe both the survivor and the victim. Shootdown errors show in the first cycle after the strobe.

// File: rtl/ctlb_l1.sv
module ctlb_l1 #(
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 24,
  parameter int ATTR_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [1:0]        lk_level,
  output logic              walk_valid,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [1:0]        rf_level,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [7:0]        rf_vmask,
  input  logic [2:0]        rf_pteidx,
  input  logic [ATTR_W-1:0] rf_attr,
  input  logic              sf_valid,
  input  logic              sf_has_addr,
  input  logic [VPN_W-1:0]  sf_vpn
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = VPN_W - 3;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [1:0]         lvl_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];
  logic [7:0]         vm_q   [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] hitv, rf_match, sf_hitv;
  logic [IDX_W-1:0]   hidx, midx, rf_idx;
  logic               rf_ok;
  logic [PPN_W-1:0]   hppn;

  function automatic logic covers(input logic [TAG_W-1:0] t, input logic [1:0] lv,
                                  input logic [VPN_W-1:0] v);
    case (lv)
      2'd0:    return t == v[VPN_W-1:3];
      2'd1:    return t[TAG_W-1:6] == v[VPN_W-1:9];
      2'd2:    return t[TAG_W-1:15] == v[VPN_W-1:18];
      default: return 1'b0;
    endcase
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hitv[e]     = vld[e] && covers(tag_q[e], lvl_q[e], lk_vpn) &&
                         (lvl_q[e] != 2'd0 || vm_q[e][lk_vpn[2:0]]);
    assign rf_match[e] = vld[e] && lvl_q[e] == rf_level && covers(tag_q[e], rf_level, rf_vpn);
    assign sf_hitv[e]  = vld[e] && covers(tag_q[e], lvl_q[e], sf_vpn);
  end

  always_comb begin
    hidx = '0;
    midx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hitv[e]) hidx = IDX_W'(e);
      if (rf_match[e]) midx = IDX_W'(e);
    end
  end

  assign lk_hit     = lk_valid && |hitv;
  assign hppn       = ppn_q[hidx];
  assign lk_attr    = lk_hit ? attr_q[hidx] : '0;
  assign lk_level   = lk_hit ? lvl_q[hidx] : 2'd0;
  assign walk_valid = lk_valid && !lk_hit;
  assign walk_vpn   = lk_vpn;

  always_comb begin
    lk_ppn = '0;
    if (lk_hit) begin
      case (lvl_q[hidx])
        2'd1:    lk_ppn = {hppn[PPN_W-1:9], lk_vpn[8:0]};
        2'd2:    lk_ppn = {hppn[PPN_W-1:18], lk_vpn[17:0]};
        default: lk_ppn = {hppn[PPN_W-1:3], lk_vpn[2:0]};
      endcase
    end
  end

  assign rf_ok  = rf_valid && !sf_valid && rf_level != 2'd3 &&
                  (rf_level != 2'd0 || rf_vmask[rf_pteidx]);
  assign rf_idx = |rf_match ? midx : rr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (sf_valid) begin
      vld <= sf_has_addr ? (vld & ~sf_hitv) : '0;
    end else if (rf_ok) begin
      vld[rf_idx] <= 1'b1;
      if (!(|rf_match)) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_ok) begin
      tag_q[rf_idx]  <= rf_vpn[VPN_W-1:3];
      lvl_q[rf_idx]  <= rf_level;
      ppn_q[rf_idx]  <= rf_ppn;
      attr_q[rf_idx] <= rf_attr;
      vm_q[rf_idx]   <= rf_vmask;
    end
  end

  p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);
  p_small_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_level == 2'd0) |-> lk_ppn[2:0] == lk_vpn[2:0]);
  p_walk_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> (!lk_hit && walk_vpn == lk_vpn));
  p_merge_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ok && |rf_match) |=> $countones(vld) == $past($countones(vld)));
  p_pointer_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ok && !(|rf_match)) |=> rr == (($past(rr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr) + 1'b1));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && !sf_has_addr) |=> !lk_hit);
endmodule

// File: tb/tb_ctlb_l1.sv
module tb_ctlb_l1;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [26:0] lk_vpn = '0;
  logic        lk_hit;
  logic [23:0] lk_ppn;
  logic [7:0]  lk_attr;
  logic [1:0]  lk_level;
  logic        walk_valid;
  logic [26:0] walk_vpn;
  logic        rf_valid = 0;
  logic [26:0] rf_vpn = '0;
  logic [1:0]  rf_level = '0;
  logic [23:0] rf_ppn = '0;
  logic [7:0]  rf_vmask = '0;
  logic [2:0]  rf_pteidx = '0;
  logic [7:0]  rf_attr = '0;
  logic        sf_valid = 0, sf_has_addr = 0;
  logic [26:0] sf_vpn = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ctlb_l1 dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [26:0] v, input logic [1:0] lv, input logic [23:0] p,
                        input logic [7:0] m, input logic [2:0] ix, input logic [7:0] a);
    @(negedge clk);
    rf_valid = 1; rf_vpn = v; rf_level = lv; rf_ppn = p; rf_vmask = m; rf_pteidx = ix; rf_attr = a;
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic flush(input logic addr, input logic [26:0] v);
    @(negedge clk);
    sf_valid = 1; sf_has_addr = addr; sf_vpn = v;
    @(negedge clk);
    sf_valid = 0;
  endtask

  task automatic look(input logic [26:0] v);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v;
    #1;
  endtask

  task automatic t_reset;
    look(27'h0123455);
    chk("R1 hit after reset", lk_hit, 0);
    chk("R1 walk after reset", walk_valid, 1);
    chk("R5 walk vpn", walk_vpn, 27'h0123455);
  endtask

  task automatic t_group;
    logic [26:0] b = 27'h0123450;
    logic [23:0] p = 24'hABCDE8;
    @(negedge clk);
    rf_valid = 1; rf_vpn = b | 27'd5; rf_level = 0; rf_ppn = p; rf_vmask = 8'b1011_0111;
    rf_pteidx = 3'd5; rf_attr = 8'h5A;
    lk_valid = 1; lk_vpn = b | 27'd5;
    #1 chk("R10 not visible before edge", lk_hit, 0);
    @(negedge clk);
    rf_valid = 0;
    #1 chk("R10 visible after edge", lk_hit, 1);
    chk("R3 ppn idx5", lk_ppn, {p[23:3], 3'd5});
    chk("R3 attr", lk_attr, 8'h5A);
    chk("R3 level", lk_level, 0);
    chk("R5 no walk on hit", walk_valid, 0);
    look(b | 27'd7);
    chk("R2 hit idx7", lk_hit, 1);
    chk("R3 ppn idx7", lk_ppn, {p[23:3], 3'd7});
    look(b | 27'd3);
    chk("R2 cleared vector bit misses", lk_hit, 0);
    chk("R5 walk on vector miss", walk_valid, 1);
    look(b | 27'h8);
    chk("R2 other tag misses", lk_hit, 0);
  endtask

  task automatic t_large;
    logic [26:0] v;
    flush(0, '0);
    refill(27'h5555200, 2'd1, 24'h3C0000, 8'h00, 3'd0, 8'h11);
    refill(27'h7040000, 2'd2, 24'h840000, 8'h00, 3'd0, 8'h22);
    v = 27'h55553FF;
    look(v);
    chk("R4 2MB hit", lk_hit, 1);
    chk("R4 2MB ppn", lk_ppn, {15'(24'h3C0000 >> 9), v[8:0]});
    chk("R4 2MB level", lk_level, 1);
    look(27'h5555400);
    chk("R4 2MB outside misses", lk_hit, 0);
    v = 27'h707ABCD;
    look(v);
    chk("R4 1GB hit", lk_hit, 1);
    chk("R4 1GB ppn", lk_ppn, {6'(24'h840000 >> 18), v[17:0]});
    chk("R4 1GB attr", lk_attr, 8'h22);
  endtask

  task automatic t_merge;
    logic [26:0] a = 27'h0000100;
    flush(0, '0);
    refill(a, 0, 24'h111110, 8'hFF, 3'd0, 8'h01);
    for (int i = 1; i <= 6; i++) refill(27'h1000000 + 27'(i * 8), 0, 24'(i * 8), 8'hFF, 3'd0, 8'h02);
    refill(a | 27'd2, 0, 24'h222220, 8'hFF, 3'd2, 8'h03);
    look(a | 27'd1);
    chk("R6 merged ppn", lk_ppn, 24'h222221);
    refill(27'h1000000 + 27'd56, 0, 24'h000038, 8'hFF, 3'd0, 8'h02);
    refill(27'h1000000 + 27'd64, 0, 24'h000040, 8'hFF, 3'd0, 8'h02);
    look(27'h1000008);
    chk("R6 first other survives", lk_hit, 1);
    look(a);
    chk("R6 merged entry evicted in turn", lk_hit, 0);
  endtask

  task automatic t_round_robin;
    flush(0, '0);
    for (int i = 0; i < 9; i++) refill(27'h2000000 + 27'(i * 8), 0, 24'(i * 8), 8'hFF, 3'd0, 8'h04);
    look(27'h2000000);
    chk("R7 first evicted", lk_hit, 0);
    for (int i = 1; i < 9; i++) begin
      look(27'h2000000 + 27'(i * 8));
      chk("R7 later kept", lk_hit, 1);
    end
  endtask

  task automatic t_dropped;
    flush(0, '0);
    refill(27'h3000010, 0, 24'h000100, 8'b1111_1011, 3'd2, 8'h05);
    look(27'h3000010);
    chk("R8 cleared pteidx bit dropped", lk_hit, 0);
    refill(27'h3000020, 2'd3, 24'h000200, 8'hFF, 3'd0, 8'h05);
    look(27'h3000020);
    chk("R8 level 3 dropped", lk_hit, 0);
  endtask

  task automatic t_shootdown;
    flush(0, '0);
    refill(27'h4000008, 0, 24'h000500, 8'hFF, 3'd0, 8'h06);
    refill(27'h4000010, 0, 24'h000600, 8'hFF, 3'd0, 8'h06);
    flush(1, 27'h400000D);
    look(27'h4000008);
    chk("R9 addressed entry removed", lk_hit, 0);
    look(27'h4000011);
    chk("R9 other entry kept", lk_hit, 1);
    @(negedge clk);
    rf_valid = 1; rf_vpn = 27'h4000020; rf_level = 0; rf_ppn = 24'h000700; rf_vmask = 8'hFF;
    rf_pteidx = 0; sf_valid = 1; sf_has_addr = 1; sf_vpn = 27'h6000000;
    @(negedge clk);
    rf_valid = 0; sf_valid = 0;
    look(27'h4000020);
    chk("R9 refill during sfence dropped", lk_hit, 0);
    flush(0, '0);
    look(27'h4000011);
    chk("R9 full flush", lk_hit, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_group;
    t_large;
    t_merge;
    t_round_robin;
    t_dropped;
    t_shootdown;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule